// File: doc/BRIEF.md
# Key-protected clock control registers

This block is a small bank of clock-generator control registers reached over a byte-wide register bus. It holds a power register, an option register and a key register. The power register sets the two oscillator enables, the CPU clock source, the prescaler enable and the system clock divide ratio. The option register sets the halt clock option, the high-speed stabilization-wait disable and the low-speed clock external output enable. The block drives these settings straight to its output pins, and it also gives the divide ratio as a one-hot code.

The power and option registers are guarded by a key. Writing the unlock byte to the key register opens both registers, and writing any other byte closes them again. A lock state machine has two states, `ST_LOCKED` and `ST_UNLOCKED`. The transition `KEY_MATCH` is taken on a key write of the unlock byte, and `KEY_MISS` is taken on a key write of any other byte. No other event changes the state.

The power register refuses writes that would starve the CPU of a clock. The oscillator currently selected as the CPU source cannot be switched off. The source cannot be moved onto an oscillator that is not enabled, is not kept enabled by the same write, and is not reporting ready.

Top module: `clk_ctrl_regs`

## Requirements
- R1: The key register sits at address 2. It reads back the last byte written to it. A key write of 0x96 puts the block in the unlocked state. A key write of any other byte puts it in the locked state.
- R2: While locked, a write to the power register (address 0) or to the option register (address 1) changes neither its readback nor any output pin.
- R3: After reset the power register reads 0x27. This means divide field 00, prescaler on, source high-speed, and both enables 1. The option register reads 0x08, the key register reads 0x00, and the block is locked.
- R4: An unlocked power write applies the following fields. Bits 7:6 are the divide field, bit 5 is the prescaler enable, bit 2 is the source select (1 = high-speed), bit 1 is the high-speed enable and bit 0 is the low-speed enable. The applied fields appear on the matching pins one cycle later. Bits 4:3 always read 0.
- R5: `div_onehot` has exactly one bit set, at the index given by the divide field. Bit 0 means 1/1 (field 00), bit 1 means 1/2 (01), bit 2 means 1/4 (10) and bit 3 means 1/8 (11).
- R6: An unlocked power write of 0 to the enable of the oscillator selected as CPU source before the write is ignored. That enable stays 1, and the other fields of the same write still apply.
- R7: A source change to high-speed takes effect only if three conditions all hold: the high-speed enable is already 1, the same write sets bit 1, and `hs_ready` is high. The same rule applies to a change to low-speed, using bit 0 and `ls_ready`. Otherwise the source keeps its value.
- R8: An unlocked option write stores bits 7:4 (halt option, shown on `halt_opt`), bit 3 (stabilization-wait disable, shown on `hs_wait_off`) and bit 0 (low-speed external output, shown on `ls_clk_out_en`). Bits 2:1 always read 0.
- R9: The unlocked state lasts across any number of power and option writes. It ends only when a key write of a byte other than 0x96 occurs.
- R10: Address 3 reads 0x00, and a write to it changes no register and no pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 2 | Register select: 0 power, 1 option, 2 key, 3 unused |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Readback of the addressed register, combinational |
| hs_ready | input | 1 | High-speed oscillator reports a stable clock |
| ls_ready | input | 1 | Low-speed oscillator reports a stable clock |
| hs_osc_en | output | 1 | High-speed oscillator enable |
| ls_osc_en | output | 1 | Low-speed oscillator enable |
| cpu_src_hs | output | 1 | CPU clock source, 1 = high-speed |
| presc_en | output | 1 | Prescaler enable |
| div_onehot | output | 4 | One-hot system clock divide ratio |
| halt_opt | output | 4 | Halt clock option field |
| hs_wait_off | output | 1 | High-speed stabilization wait disabled |
| ls_clk_out_en | output | 1 | Low-speed clock external output enable |

## Verification
The assertions check the following on every cycle:
- The selected source oscillator is always enabled.
- Every rise or fall of the source select was preceded by a ready and enabled target.
- `div_onehot` is always one-hot.
- Reserved and unused locations read zero.
- Locked writes leave every pin stable.
- The lock state follows the last key byte written.

Only the bench's scenarios can show the rest. This covers the exact field values after each of the 256 power bytes under every ready combination, and the key readback over all 256 bytes. It also covers the reset values and the persistence of the unlocked state across a run of writes.

// File: rtl/clkreg_pkg.sv
package clkreg_pkg;

    typedef enum logic {
        ST_LOCKED   = 1'b0,
        ST_UNLOCKED = 1'b1
    } lock_state_t;

    localparam int          DATA_W   = 8;
    localparam int          ADDR_PWR = 0;
    localparam int          ADDR_OPT = 1;
    localparam int          ADDR_KEY = 2;
    localparam logic [7:0]  PWR_RST  = 8'h27;
    localparam logic [7:0]  OPT_RST  = 8'h08;
    localparam logic [7:0]  KEY_RST  = 8'h00;

endpackage

// File: rtl/clkreg_lock.sv
module clkreg_lock
    import clkreg_pkg::*;
#(
    parameter logic [DATA_W-1:0] UNLOCK_KEY = 8'h96
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              key_wr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] key_q,
    output logic              unlocked
);

    lock_state_t state_q, state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_LOCKED;
            key_q   <= KEY_RST;
        end else begin
            state_q <= state_d;
            if (key_wr) key_q <= wdata;
        end
    end

    // transitions: KEY_MATCH / KEY_MISS
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LOCKED:   if (key_wr && wdata == UNLOCK_KEY) state_d = ST_UNLOCKED;
            ST_UNLOCKED: if (key_wr && wdata != UNLOCK_KEY) state_d = ST_LOCKED;
            default:     state_d = ST_LOCKED;
        endcase
    end

    // outputs
    always_comb begin
        unique case (state_q)
            ST_UNLOCKED: unlocked = 1'b1;
            default:     unlocked = 1'b0;
        endcase
    end

endmodule

// File: rtl/clkreg_power.sv
module clkreg_power
    import clkreg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    input  logic              hs_ready,
    input  logic              ls_ready,
    output logic [DATA_W-1:0] rd_q,
    output logic [1:0]        div_sel,
    output logic              presc_en,
    output logic              src_hs,
    output logic              hs_en,
    output logic              ls_en
);

    logic       hs_en_d, ls_en_d, src_d;
    logic       unused_rsv;

    assign unused_rsv = ^wdata[4:3];

    always_comb begin
        // the running source's oscillator may not be stopped
        hs_en_d = wdata[1] | src_hs;
        ls_en_d = wdata[0] | ~src_hs;
        src_d   = src_hs;
        if (wdata[2] && !src_hs && hs_en && wdata[1] && hs_ready)
            src_d = 1'b1;
        else if (!wdata[2] && src_hs && ls_en && wdata[0] && ls_ready)
            src_d = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_sel  <= PWR_RST[7:6];
            presc_en <= PWR_RST[5];
            src_hs   <= PWR_RST[2];
            hs_en    <= PWR_RST[1];
            ls_en    <= PWR_RST[0];
        end else if (wr_en) begin
            div_sel  <= wdata[7:6];
            presc_en <= wdata[5];
            src_hs   <= src_d;
            hs_en    <= hs_en_d;
            ls_en    <= ls_en_d;
        end
    end

    assign rd_q = {div_sel, presc_en, 2'b00, src_hs, hs_en, ls_en};

endmodule

// File: rtl/clkreg_option.sv
module clkreg_option
    import clkreg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rd_q,
    output logic [3:0]        halt_opt,
    output logic              wait_off,
    output logic              ext_out
);

    logic unused_rsv;

    assign unused_rsv = ^wdata[2:1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            halt_opt <= OPT_RST[7:4];
            wait_off <= OPT_RST[3];
            ext_out  <= OPT_RST[0];
        end else if (wr_en) begin
            halt_opt <= wdata[7:4];
            wait_off <= wdata[3];
            ext_out  <= wdata[0];
        end
    end

    assign rd_q = {halt_opt, wait_off, 2'b00, ext_out};

endmodule

// File: rtl/clk_ctrl_regs.sv
module clk_ctrl_regs
    import clkreg_pkg::*;
#(
    parameter int                ADDR_W     = 2,
    parameter int                DIV_N      = 4,
    parameter logic [DATA_W-1:0] UNLOCK_KEY = 8'h96
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              hs_ready,
    input  logic              ls_ready,
    output logic              hs_osc_en,
    output logic              ls_osc_en,
    output logic              cpu_src_hs,
    output logic              presc_en,
    output logic [DIV_N-1:0]  div_onehot,
    output logic [3:0]        halt_opt,
    output logic              hs_wait_off,
    output logic              ls_clk_out_en
);

    localparam int SEL_W = $clog2(DIV_N);

    logic              sel_pwr, sel_opt, sel_key;
    logic              unlocked;
    logic [DATA_W-1:0] key_q, pwr_q, opt_q;
    logic [1:0]        div_sel;

    assign sel_pwr = (bus_addr == ADDR_W'(ADDR_PWR));
    assign sel_opt = (bus_addr == ADDR_W'(ADDR_OPT));
    assign sel_key = (bus_addr == ADDR_W'(ADDR_KEY));

    clkreg_lock #(.UNLOCK_KEY(UNLOCK_KEY)) u_lock (
        .clk      (clk),
        .rst_n    (rst_n),
        .key_wr   (bus_wr && sel_key),
        .wdata    (bus_wdata),
        .key_q    (key_q),
        .unlocked (unlocked)
    );

    clkreg_power u_pwr (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (bus_wr && sel_pwr && unlocked),
        .wdata    (bus_wdata),
        .hs_ready (hs_ready),
        .ls_ready (ls_ready),
        .rd_q     (pwr_q),
        .div_sel  (div_sel),
        .presc_en (presc_en),
        .src_hs   (cpu_src_hs),
        .hs_en    (hs_osc_en),
        .ls_en    (ls_osc_en)
    );

    clkreg_option u_opt (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (bus_wr && sel_opt && unlocked),
        .wdata    (bus_wdata),
        .rd_q     (opt_q),
        .halt_opt (halt_opt),
        .wait_off (hs_wait_off),
        .ext_out  (ls_clk_out_en)
    );

    for (genvar i = 0; i < DIV_N; i++) begin : g_div
        assign div_onehot[i] = (SEL_W'(div_sel) == SEL_W'(i));
    end

    always_comb begin
        bus_rdata = '0;
        if (sel_pwr)      bus_rdata = pwr_q;
        else if (sel_opt) bus_rdata = opt_q;
        else if (sel_key) bus_rdata = key_q;
    end

endmodule

// File: rtl/clk_ctrl_regs_chk.sv
module clk_ctrl_regs_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] bus_addr,
    input logic       bus_wr,
    input logic [7:0] bus_wdata,
    input logic [7:0] bus_rdata,
    input logic       hs_ready,
    input logic       ls_ready,
    input logic       hs_osc_en,
    input logic       ls_osc_en,
    input logic       cpu_src_hs,
    input logic       presc_en,
    input logic [3:0] div_onehot,
    input logic [3:0] halt_opt,
    input logic       hs_wait_off,
    input logic       ls_clk_out_en,
    input logic       unlocked
);

    a_r1_key_state: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 2'd2) |=> (unlocked == ($past(bus_wdata) == 8'h96)));

    a_r2_pwr_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 2'd0 && !unlocked)
        |=> $stable({hs_osc_en, ls_osc_en, cpu_src_hs, presc_en, div_onehot}));

    a_r2_opt_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 2'd1 && !unlocked)
        |=> $stable({halt_opt, hs_wait_off, ls_clk_out_en}));

    a_r4_pwr_rsv_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == 2'd0) |-> (bus_rdata[4:3] == 2'b00));

    a_r5_div_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(div_onehot) == 1);

    a_r6_src_hs_running: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_src_hs |-> hs_osc_en);

    a_r6_src_ls_running: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_src_hs |-> ls_osc_en);

    a_r7_to_hs_ready: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_src_hs) |-> $past(hs_ready && hs_osc_en));

    a_r7_to_ls_ready: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cpu_src_hs) |-> $past(ls_ready && ls_osc_en));

    a_r8_opt_rsv_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == 2'd1) |-> (bus_rdata[2:1] == 2'b00));

    a_r10_hole_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == 2'd3) |-> (bus_rdata == 8'h00));

endmodule

bind clk_ctrl_regs clk_ctrl_regs_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_addr      (bus_addr),
    .bus_wr        (bus_wr),
    .bus_wdata     (bus_wdata),
    .bus_rdata     (bus_rdata),
    .hs_ready      (hs_ready),
    .ls_ready      (ls_ready),
    .hs_osc_en     (hs_osc_en),
    .ls_osc_en     (ls_osc_en),
    .cpu_src_hs    (cpu_src_hs),
    .presc_en      (presc_en),
    .div_onehot    (div_onehot),
    .halt_opt      (halt_opt),
    .hs_wait_off   (hs_wait_off),
    .ls_clk_out_en (ls_clk_out_en),
    .unlocked      (unlocked)
);

// File: tb/sim_clk_ctrl_regs.sv
`timescale 1ns/1ps
module sim_clk_ctrl_regs;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       hs_ready = 1'b1;
    logic       ls_ready = 1'b1;
    logic       hs_osc_en, ls_osc_en, cpu_src_hs, presc_en;
    logic [3:0] div_onehot, halt_opt;
    logic       hs_wait_off, ls_clk_out_en;

    int n_chk = 0;
    int n_fail = 0;

    // bench model state
    logic [1:0] m_div;
    logic       m_presc, m_src, m_hs, m_ls;
    logic [7:0] m_opt, m_key;

    always #4 clk = ~clk;

    clk_ctrl_regs u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .hs_ready(hs_ready),
        .ls_ready(ls_ready), .hs_osc_en(hs_osc_en), .ls_osc_en(ls_osc_en),
        .cpu_src_hs(cpu_src_hs), .presc_en(presc_en), .div_onehot(div_onehot),
        .halt_opt(halt_opt), .hs_wait_off(hs_wait_off), .ls_clk_out_en(ls_clk_out_en)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    function automatic logic [7:0] pwr_exp();
        return {m_div, m_presc, 2'b00, m_src, m_hs, m_ls};
    endfunction

    // expected effect of an unlocked power write (R4, R6, R7)
    task automatic model_pwr(input logic [7:0] d);
        logic nsrc;
        nsrc = m_src;
        if (d[2] && !m_src && m_hs && d[1] && hs_ready) nsrc = 1'b1;
        if (!d[2] && m_src && m_ls && d[0] && ls_ready) nsrc = 1'b0;
        m_hs    = d[1] | m_src;
        m_ls    = d[0] | ~m_src;
        m_src   = nsrc;
        m_div   = d[7:6];
        m_presc = d[5];
    endtask

    task automatic check_pins(input string tag);
        chk(tag, {28'd0, hs_osc_en, ls_osc_en, cpu_src_hs, presc_en},
                 {28'd0, m_hs, m_ls, m_src, m_presc});
        chk("R5 div_onehot", {28'd0, div_onehot}, 32'd1 << m_div);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] d;
        m_div = 2'b00; m_presc = 1'b1; m_src = 1'b1; m_hs = 1'b1; m_ls = 1'b1;
        m_opt = 8'h08; m_key = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R3 reset state
        rd(2'd0, d); chk("R3 power reset", {24'd0, d}, 32'h27);
        rd(2'd1, d); chk("R3 option reset", {24'd0, d}, 32'h08);
        rd(2'd2, d); chk("R3 key reset", {24'd0, d}, 32'h00);
        check_pins("R3 reset pins");
        chk("R3 option pins", {26'd0, halt_opt, hs_wait_off, ls_clk_out_en}, 32'h2);

        // R2 locked after reset
        wr(2'd0, 8'hC0);
        rd(2'd0, d); chk("R2 locked power", {24'd0, d}, {24'd0, pwr_exp()});
        check_pins("R2 locked pins");
        wr(2'd1, 8'hF1);
        rd(2'd1, d); chk("R2 locked option", {24'd0, d}, {24'd0, m_opt});

        // R4 R6 R7 sweep of every power byte under each ready combination
        wr(2'd2, 8'h96); m_key = 8'h96;
        for (int v = 0; v < 256; v++) begin
            for (int r = 0; r < 4; r++) begin
                @(negedge clk);
                hs_ready = r[1];
                ls_ready = r[0];
                wr(2'd0, v[7:0]);
                model_pwr(v[7:0]);
                rd(2'd0, d);
                chk("R4 power readback", {24'd0, d}, {24'd0, pwr_exp()});
                check_pins("R6 enable pins");
            end
        end

        // R7 directed: switch refused without ready, then taken with it
        wr(2'd0, 8'h27); model_pwr(8'h27);
        @(negedge clk); ls_ready = 1'b0; hs_ready = 1'b1;
        wr(2'd0, 8'h23); model_pwr(8'h23);
        chk("R7 switch refused", {31'd0, cpu_src_hs}, 32'd1);
        @(negedge clk); ls_ready = 1'b1;
        wr(2'd0, 8'h23); model_pwr(8'h23);
        chk("R7 switch taken", {31'd0, cpu_src_hs}, 32'd0);
        // R6 directed: stop the running low-speed oscillator, refused
        wr(2'd0, 8'h02); model_pwr(8'h02);
        chk("R6 running kept", {30'd0, hs_osc_en, ls_osc_en}, 32'h3);

        // R8 R9 option sweep while staying unlocked
        for (int v = 0; v < 256; v++) begin
            wr(2'd1, v[7:0]);
            m_opt = v[7:0] & 8'hF9;
            rd(2'd1, d);
            chk("R8 option readback", {24'd0, d}, {24'd0, m_opt});
            chk("R9 option pins", {26'd0, halt_opt, hs_wait_off, ls_clk_out_en},
                {26'd0, m_opt[7:3], m_opt[0]});
        end

        // R1 key sweep: readback and lock state seen through option writes
        for (int k = 0; k < 256; k++) begin
            wr(2'd2, k[7:0]); m_key = k[7:0];
            rd(2'd2, d);
            chk("R1 key readback", {24'd0, d}, {24'd0, m_key});
            wr(2'd1, ~m_opt);
            if (k == 8'h96) m_opt = (~m_opt) & 8'hF9;
            rd(2'd1, d);
            chk("R1 lock state", {24'd0, d}, {24'd0, m_opt});
        end

        // R10 unused address: reads 0, writes touch nothing
        wr(2'd2, 8'h96); m_key = 8'h96;
        wr(2'd3, 8'hFF);
        rd(2'd3, d); chk("R10 hole read", {24'd0, d}, 32'h00);
        rd(2'd0, d); chk("R10 power kept", {24'd0, d}, {24'd0, pwr_exp()});
        rd(2'd1, d); chk("R10 option kept", {24'd0, d}, {24'd0, m_opt});
        rd(2'd2, d); chk("R10 key kept", {24'd0, d}, 32'h96);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule